// File: doc/BRIEF.md
# Multi-CPU Interrupt Distributor

This block collects interrupt requests from many sources and routes them to a small set of processors. It recognises three kinds of source. Sixteen software IDs are raised by a register write. Sixteen private lines per processor reach only their own CPU. Shared peripheral lines can be steered to any subset of CPUs. Each ID has an enable bit, a pending condition, a five-bit priority and a trigger mode. Each shared ID also has a CPU target mask.

Software programs the block through a plain word-addressed write port and reads it back through a registered read port. Peripheral lines pass through a two-stage synchroniser before they are used. For every CPU, the block continuously presents the most urgent forwardable interrupt as an ID and a valid flag. This output is registered, so it appears one cycle after the state that selects it. Acknowledge and end-of-interrupt handling belong to the per-CPU logic downstream.

Top module: `irq_distributor`

## Requirements
- R1: After reset, no CPU output is valid. All enables, priorities and targets read 0, forwarding is off, and every shared and private ID reads as level-triggered (field 01).
- R2: With the default of 64 IDs, the word addresses are as follows. Control is at 0, with bit 0 as the forwarding enable. The software trigger is at 1. Enable-set is at 2–3, enable-clear at 4–5 and pending-clear at 6–7. Priority is at 8–23, trigger mode at 24–27 and targets at 28–43. Bit `i%32` of word `base+i/32` belongs to ID i. Read data appears one cycle after `rd_addr`.
- R3: In the enable-set and enable-clear words, writing a 1 to a bit sets or clears that ID's enable, and writing a 0 leaves the bit unchanged. Both word groups read back the enable bits.
- R4: Priority uses one byte per ID at bits `8*(i%4)+7 : 8*(i%4)` of word `8+i/4`. Only bits 7:3 are kept, and bits 2:0 always read 0. A lower value is more urgent.
- R5: The trigger mode uses two bits per ID at bits `2*(i%16)+1 : 2*(i%16)` of word `24+i/16`. Software IDs read 10 and private IDs read 01. A shared ID reads 01 for level or 11 for rising edge: its low bit is fixed at 1 and only its high bit is writable.
- R6: The target mask uses one byte per ID at bits `8*(i%4)+7 : 8*(i%4)` of word `28+i/4`, and bit n selects CPU n. Writes to IDs below 32 are ignored and read back 0. IDs below 32 are never filtered by a target mask.
- R7: A write to the software trigger word sets ID `data[3:0]` pending on every CPU n for which `data[16+n]` is 1, and on no other CPU.
- R8: For a level-triggered ID, the ID is pending exactly while its synchronised input is high.
- R9: An edge-triggered shared ID becomes pending on a 0-to-1 transition of its synchronised input. It stays pending until a 1 is written to its bit in the pending-clear words. These words also clear software IDs on all CPUs.
- R10: Disabling an ID does not clear its pending state, and the ID is forwarded again once it is re-enabled.
- R11: Each CPU output carries the pending, enabled and targeted ID with the lowest priority value. When two such IDs share a priority, the lower ID wins.
- R12: While the forwarding enable is 0, no CPU output is valid.
- R13: Private line `irq_ppi[16*n+k]` drives ID `16+k` for CPU n only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | 32 | Read data, one cycle after rd_addr |
| irq_ppi | input | NUM_CPUS*16 | Private interrupt lines, 16 per CPU |
| irq_spi | input | NUM_IDS-32 | Shared interrupt lines, for IDs 32 and above |
| irq_valid | output | NUM_CPUS | An interrupt is presented to CPU n |
| irq_id | output | NUM_CPUS*ID_W | ID presented to CPU n, in slice n |

## Verification
The checks assume that every interrupt line holds each level for at least one full clock, so that the synchroniser sees every rising edge. They also assume writes only target addresses inside the map. The stimulus changes lines and write strobes only on falling edges and keeps each pulse high for a whole cycle. Before any output is compared, it waits a fixed settling window that covers the two synchroniser stages, the pending latch and the output register. Software trigger IDs are limited to 0–15 by the width of their field, so the stimulus never needs out-of-range values.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
    localparam int SGI_N    = 16;
    localparam int PPI_N    = 16;
    localparam int SPI_BASE = 32;
    localparam int PRIO_W   = 5;

    localparam logic [1:0] CFG_SOFT  = 2'b10;
    localparam logic [1:0] CFG_LEVEL = 2'b01;

    localparam int A_CTRL   = 0;
    localparam int A_SWTRIG = 1;

    function automatic int a_en_set(int n);   return 2; endfunction
    function automatic int a_en_clr(int n);   return 2 + n / 32; endfunction
    function automatic int a_pend_clr(int n); return 2 + 2 * (n / 32); endfunction
    function automatic int a_prio(int n);     return 2 + 3 * (n / 32); endfunction
    function automatic int a_cfg(int n);      return a_prio(n) + n / 4; endfunction
    function automatic int a_tgt(int n);      return a_cfg(n) + n / 16; endfunction
endpackage

// File: rtl/irqd_sync.sv
module irqd_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/irqd_arb.sv
module irqd_arb #(
    parameter int NUM_IDS = 64,
    parameter int PRIO_W  = 5,
    parameter int ID_W    = $clog2(NUM_IDS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_IDS-1:0]        cand,
    input  logic [NUM_IDS*PRIO_W-1:0] prio,
    output logic                      valid,
    output logic [ID_W-1:0]           id
);
    typedef struct packed {
        logic            valid;
        logic [ID_W-1:0] id;
    } pick_t;

    pick_t pick_d, pick_q;
    logic [PRIO_W-1:0] best_p;

    always_comb begin
        pick_d = '0;
        best_p = '1;
        for (int i = 0; i < NUM_IDS; i++) begin
            // strict compare keeps the lower ID on a tie
            if (cand[i] && (!pick_d.valid || prio[i*PRIO_W +: PRIO_W] < best_p)) begin
                pick_d.valid = 1'b1;
                pick_d.id    = ID_W'(i);
                best_p       = prio[i*PRIO_W +: PRIO_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pick_q <= '0;
        else        pick_q <= pick_d;
    end

    assign valid = pick_q.valid;
    assign id    = pick_q.id;
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
    import irqd_pkg::*;
#(
    parameter int NUM_IDS  = 64,
    parameter int NUM_CPUS = 2,
    parameter int ADDR_W   = 8,
    parameter int ID_W     = $clog2(NUM_IDS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [31:0]              wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [31:0]              rd_data,
    input  logic [NUM_CPUS*16-1:0]   irq_ppi,
    input  logic [NUM_IDS-33:0]      irq_spi,
    output logic [NUM_CPUS-1:0]      irq_valid,
    output logic [NUM_CPUS*ID_W-1:0] irq_id
);
    localparam int SPI_N   = NUM_IDS - SPI_BASE;
    localparam int PPI_ALL = NUM_CPUS * PPI_N;
    localparam int SYNC_W  = PPI_ALL + SPI_N;
    localparam int EN_SET  = a_en_set(NUM_IDS);
    localparam int EN_CLR  = a_en_clr(NUM_IDS);
    localparam int PND_CLR = a_pend_clr(NUM_IDS);
    localparam int PRIO_B  = a_prio(NUM_IDS);
    localparam int CFG_B   = a_cfg(NUM_IDS);
    localparam int TGT_B   = a_tgt(NUM_IDS);

    typedef struct packed {
        logic                              dist_en;
        logic [NUM_IDS-1:0]                en;
        logic [NUM_IDS-1:0][PRIO_W-1:0]    prio;
        logic [SPI_N-1:0]                  edge_mode;
        logic [SPI_N-1:0][NUM_CPUS-1:0]    tgt;
        logic [NUM_CPUS-1:0][SGI_N-1:0]    sgi_pend;
        logic [SPI_N-1:0]                  spi_lat;
        logic [SPI_N-1:0]                  spi_prev;
        logic [31:0]                       rd_data;
    } state_t;

    state_t st_d, st_q;

    logic [SYNC_W-1:0]   sync_out;
    logic [PPI_ALL-1:0]  ppi_s;
    logic [SPI_N-1:0]    spi_s;
    logic [NUM_CPUS-1:0][NUM_IDS-1:0] cand;

    irqd_sync #(.W(SYNC_W), .STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({irq_spi, irq_ppi}),
        .q    (sync_out)
    );

    assign ppi_s = sync_out[PPI_ALL-1:0];
    assign spi_s = sync_out[SYNC_W-1:PPI_ALL];

    always_comb begin
        int wa;
        int ra;
        st_d = st_q;
        st_d.spi_prev = spi_s;
        wa = int'(wr_addr);
        ra = int'(rd_addr);

        if (wr_en) begin
            if (wa == A_CTRL) st_d.dist_en = wr_data[0];
            if (wa == A_SWTRIG) begin
                for (int c = 0; c < NUM_CPUS; c++)
                    if (wr_data[16+c]) st_d.sgi_pend[c][wr_data[3:0]] = 1'b1;
            end
            for (int i = 0; i < NUM_IDS; i++) begin
                if (wa == EN_SET + i/32 && wr_data[i%32]) st_d.en[i] = 1'b1;
                if (wa == EN_CLR + i/32 && wr_data[i%32]) st_d.en[i] = 1'b0;
                if (wa == PRIO_B + i/4)
                    st_d.prio[i] = wr_data[8*(i%4)+3 +: PRIO_W];
            end
            for (int i = 0; i < SGI_N; i++) begin
                if (wa == PND_CLR && wr_data[i])
                    for (int c = 0; c < NUM_CPUS; c++) st_d.sgi_pend[c][i] = 1'b0;
            end
            for (int s = 0; s < SPI_N; s++) begin
                if (wa == PND_CLR + (s+SPI_BASE)/32 && wr_data[(s+SPI_BASE)%32])
                    st_d.spi_lat[s] = 1'b0;
                if (wa == CFG_B + (s+SPI_BASE)/16)
                    st_d.edge_mode[s] = wr_data[2*((s+SPI_BASE)%16)+1];
                if (wa == TGT_B + (s+SPI_BASE)/4)
                    st_d.tgt[s] = wr_data[8*((s+SPI_BASE)%4) +: NUM_CPUS];
            end
        end

        // a new edge wins over a clear in the same cycle
        for (int s = 0; s < SPI_N; s++)
            if (st_q.edge_mode[s] && spi_s[s] && !st_q.spi_prev[s]) st_d.spi_lat[s] = 1'b1;

        st_d.rd_data = '0;
        if (ra == A_CTRL) st_d.rd_data[0] = st_q.dist_en;
        for (int i = 0; i < NUM_IDS; i++) begin
            if (ra == EN_SET + i/32 || ra == EN_CLR + i/32) st_d.rd_data[i%32] = st_q.en[i];
            if (ra == PRIO_B + i/4) st_d.rd_data[8*(i%4)+3 +: PRIO_W] = st_q.prio[i];
        end
        for (int i = 0; i < SGI_N; i++)
            if (ra == CFG_B) st_d.rd_data[2*i +: 2] = CFG_SOFT;
        for (int i = SGI_N; i < SPI_BASE; i++)
            if (ra == CFG_B + i/16) st_d.rd_data[2*(i%16) +: 2] = CFG_LEVEL;
        for (int s = 0; s < SPI_N; s++) begin
            if (ra == CFG_B + (s+SPI_BASE)/16)
                st_d.rd_data[2*((s+SPI_BASE)%16) +: 2] = {st_q.edge_mode[s], 1'b1};
            if (ra == TGT_B + (s+SPI_BASE)/4)
                st_d.rd_data[8*((s+SPI_BASE)%4) +: NUM_CPUS] = st_q.tgt[s];
        end
    end

    always_comb begin
        for (int c = 0; c < NUM_CPUS; c++) begin
            for (int i = 0; i < SGI_N; i++)
                cand[c][i] = st_q.sgi_pend[c][i];
            for (int k = 0; k < PPI_N; k++)
                cand[c][SGI_N+k] = ppi_s[c*PPI_N+k];
            for (int s = 0; s < SPI_N; s++)
                cand[c][SPI_BASE+s] = (st_q.edge_mode[s] ? st_q.spi_lat[s] : spi_s[s])
                                      && st_q.tgt[s][c];
            cand[c] = cand[c] & st_q.en & {NUM_IDS{st_q.dist_en}};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.rd_data;

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        irqd_arb #(.NUM_IDS(NUM_IDS), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
            .clk  (clk),
            .rst_n(rst_n),
            .cand (cand[c]),
            .prio (st_q.prio),
            .valid(irq_valid[c]),
            .id   (irq_id[c*ID_W +: ID_W])
        );
    end

    logic                      obs_dist_en;
    logic [NUM_IDS-1:0]        obs_en;
    logic [SPI_N*NUM_CPUS-1:0] obs_tgt;
    assign obs_dist_en = st_q.dist_en;
    assign obs_en      = st_q.en;
    assign obs_tgt     = st_q.tgt;
endmodule

// File: rtl/irq_distributor_chk.sv
module irq_distributor_chk
    import irqd_pkg::*;
#(
    parameter int NUM_IDS  = 64,
    parameter int NUM_CPUS = 2,
    parameter int ADDR_W   = 8,
    parameter int ID_W     = $clog2(NUM_IDS)
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               dist_en,
    input logic [NUM_IDS-1:0]                 en,
    input logic [(NUM_IDS-32)*NUM_CPUS-1:0]   tgt,
    input logic [ADDR_W-1:0]                  rd_addr,
    input logic [31:0]                        rd_data,
    input logic [NUM_CPUS-1:0]                irq_valid,
    input logic [NUM_CPUS*ID_W-1:0]           irq_id
);
    localparam int PRIO_B = a_prio(NUM_IDS);
    localparam int CFG_B  = a_cfg(NUM_IDS);

    logic [NUM_IDS-1:0]               en_prev;
    logic [(NUM_IDS-32)*NUM_CPUS-1:0] tgt_prev;
    logic [ADDR_W-1:0]                ra_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_prev  <= '0;
            tgt_prev <= '0;
            ra_prev  <= '0;
        end else begin
            en_prev  <= en;
            tgt_prev <= tgt;
            ra_prev  <= rd_addr;
        end
    end

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !dist_en |=> (irq_valid == '0)); // R12

    AST_PRIO_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(ra_prev) >= PRIO_B && int'(ra_prev) < CFG_B) |-> ((rd_data & 32'h0707_0707) == 32'h0)); // R4

    AST_SOFT_CFG_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(ra_prev) == CFG_B) |-> (rd_data == 32'hAAAA_AAAA)); // R5

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        AST_VALID_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
            irq_valid[c] |-> en_prev[irq_id[c*ID_W +: ID_W]]); // R3

        AST_VALID_TARGETED: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_valid[c] && int'(irq_id[c*ID_W +: ID_W]) >= 32)
            |-> tgt_prev[(int'(irq_id[c*ID_W +: ID_W]) - 32) * NUM_CPUS + c]); // R6
    end
endmodule

bind irq_distributor irq_distributor_chk #(
    .NUM_IDS (NUM_IDS),
    .NUM_CPUS(NUM_CPUS),
    .ADDR_W  (ADDR_W),
    .ID_W    (ID_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dist_en  (obs_dist_en),
    .en       (obs_en),
    .tgt      (obs_tgt),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .irq_valid(irq_valid),
    .irq_id   (irq_id)
);

// File: tb/irq_distributor_tb.sv
`timescale 1ns/1ps
module irq_distributor_tb;
    localparam int NI = 64;
    localparam int NC = 2;
    localparam int AW = 8;
    localparam int IW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic [NC*16-1:0] irq_ppi = '0;
    logic [NI-33:0] irq_spi = '0;
    logic [NC-1:0] irq_valid;
    logic [NC*IW-1:0] irq_id;

    always #10 clk = ~clk;

    irq_distributor #(.NUM_IDS(NI), .NUM_CPUS(NC), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_ppi(irq_ppi), .irq_spi(irq_spi),
        .irq_valid(irq_valid), .irq_id(irq_id)
    );

    typedef struct {
        int    kind;   // 0: CPU output, 1: read data
        int    cpu;
        longint expv;
        string tag;
    } item_t;

    item_t sb[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                item_t it;
                longint act;
                it = sb.pop_front();
                if (it.kind == 0)
                    act = irq_valid[it.cpu] ? longint'(irq_id[it.cpu*IW +: IW]) : -1;
                else
                    act = longint'(rd_data);
                checks++;
                if (act != it.expv) begin
                    fails++;
                    $display("FAIL %s: actual=%0h expected=%0h", it.tag, act, it.expv);
                end
            end
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic exp_out(input int cpu, input int id, input string tag);
        item_t it;
        it.kind = 0; it.cpu = cpu; it.expv = id; it.tag = tag;
        @(negedge clk);
        sb.push_back(it);
        repeat (2) @(negedge clk);
    endtask

    task automatic exp_rd(input int a, input logic [31:0] v, input string tag);
        item_t it;
        @(negedge clk);
        rd_addr = AW'(a);
        @(negedge clk);
        it.kind = 1; it.cpu = 0; it.expv = longint'(v); it.tag = tag;
        sb.push_back(it);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        settle();
        // R1 reset state
        exp_out(0, -1, "R1 cpu0 idle");
        exp_out(1, -1, "R1 cpu1 idle");
        exp_rd(0,  32'h0, "R1 control off");
        exp_rd(8,  32'h0, "R1 priority zero");
        exp_rd(2,  32'h0, "R1 enables clear");
        exp_rd(25, 32'h5555_5555, "R1 private level");
        exp_rd(26, 32'h5555_5555, "R1 shared level");
        exp_rd(38, 32'h0, "R1 targets zero");

        // level shared ID 40 -> cpu0, forwarding off first
        wr(3, 32'h0000_0100);
        wr(38, 32'h0000_0001);
        irq_spi[8] = 1'b1;
        settle();
        exp_out(0, -1, "R12 forwarding off");
        wr(0, 32'h1);
        settle();
        exp_rd(0, 32'h1, "R2 control readback");
        exp_out(0, 40, "R8 level pending");
        exp_out(1, -1, "R6 not targeted");
        wr(5, 32'h0);
        settle();
        exp_out(0, 40, "R3 zero write no effect");
        exp_rd(3, 32'h0000_0100, "R3 enable readback");
        wr(5, 32'h0000_0100);
        settle();
        exp_out(0, -1, "R3 enable clear");
        exp_rd(5, 32'h0, "R3 clear readback");
        wr(3, 32'h0000_0100);
        irq_spi[8] = 1'b0;
        settle();
        exp_out(0, -1, "R8 level drop");

        // edge shared ID 41 -> cpu1
        wr(26, 32'h0008_0000);
        exp_rd(26, 32'h555D_5555, "R5 edge mode readback");
        wr(3, 32'h0000_0300);
        wr(38, 32'h0000_0201);
        exp_rd(38, 32'h0000_0201, "R6 target readback");
        @(negedge clk); irq_spi[9] = 1'b1;
        @(negedge clk); irq_spi[9] = 1'b0;
        settle();
        exp_out(1, 41, "R9 edge latched");
        wr(5, 32'h0000_0200);
        settle();
        exp_out(1, -1, "R10 disabled");
        wr(3, 32'h0000_0200);
        settle();
        exp_out(1, 41, "R10 pending kept");
        wr(7, 32'h0000_0200);
        settle();
        exp_out(1, -1, "R9 pending clear");

        // priority field
        wr(18, 32'h0000_00FF);
        exp_rd(18, 32'h0000_00F8, "R4 low bits dropped");

        // software IDs 3 and 5 on cpu0
        wr(2, 32'h0000_0028);
        wr(8, 32'h4000_0000);
        wr(9, 32'h0000_2000);
        wr(1, 32'h0001_0003);
        wr(1, 32'h0001_0005);
        settle();
        exp_out(0, 5, "R11 lowest priority value");
        exp_out(1, -1, "R7 unlisted cpu");
        wr(9, 32'h0000_4000);
        settle();
        exp_out(0, 3, "R11 tie lowest id");
        wr(1, 32'h0002_0003);
        settle();
        exp_out(1, 3, "R7 listed cpu");
        exp_rd(24, 32'hAAAA_AAAA, "R5 software fixed");
        wr(24, 32'hFFFF_FFFF);
        exp_rd(24, 32'hAAAA_AAAA, "R5 software read-only");
        wr(28, 32'hFFFF_FFFF);
        exp_rd(28, 32'h0, "R6 low target ignored");

        // private ID 20 on cpu1 only
        wr(2, 32'h0010_0028);
        irq_ppi[16+4] = 1'b1;
        settle();
        exp_out(1, 20, "R13 private own cpu");
        exp_out(0, 3, "R13 other cpu unaffected");

        wr(0, 32'h0);
        settle();
        exp_out(0, -1, "R12 cpu0 off");
        exp_out(1, -1, "R12 cpu1 off");

        repeat (4) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule